// File: doc/BRIEF.md
# Wishbone to AXI Single-Beat Pipelined Bridge

This block lets a pipelined Wishbone master reach an AXI4 memory-mapped slave. Every Wishbone request becomes exactly one single-beat AXI transaction. Several transactions may be in flight at the same time, as long as they all go in the same direction. Before the bridge accepts a request of the other direction, all outstanding responses must have come back.

The Wishbone bus may be narrower than the AXI data bus. In that case write data is copied into every lane and the byte strobes are steered to the addressed lane. For reads, a small queue remembers the lane of each outstanding read so that the matching slice of the returned word can be picked out.

A Wishbone master can abandon its cycle by dropping `wb_cyc`, and it is expected to do so after an error. AXI cannot cancel a transaction. The bridge therefore keeps counting outstanding responses and swallows them until the count reaches zero, and it stalls any new request in the meantime. A one-entry skid buffer on the Wishbone input keeps `wb_stall` a registered signal.

Top module: `wb2axi_bridge`

## Requirements
- R1: The AXI attributes never change. AxLEN is 0 and WLAST is 1. AWID is the parameter WR_ID and ARID is RD_ID. AxSIZE is log2 of the Wishbone width in bytes (2 for 32 bits). AxBURST is 2'b01. AxLOCK is 0, AxCACHE is 4'h2 and AxPROT is 3'b010. BREADY and RREADY are always 1.
- R2: A write taken at a clock edge raises AWVALID and WVALID together in the next cycle. AWADDR is the Wishbone word address times the Wishbone byte width. AWVALID holds its address until AWREADY, and WVALID drops on WREADY independently of AWVALID.
- R3: With a 64-bit AXI bus and a 32-bit Wishbone bus, WDATA carries the write word in both halves. WSTRB is wb_sel shifted left by 4 when wb_adr[0] is 1, and unshifted when it is 0.
- R4: A read taken at an edge raises ARVALID in the next cycle, with ARADDR equal to the word address times 4. The read data returned on Wishbone is RDATA[63:32] when that request's wb_adr[0] was 1, and RDATA[31:0] otherwise. Responses are matched to requests in issue order.
- R5: A response sampled at an edge produces a one-cycle wb_ack in the next cycle when RESP[1] is 0 (codes 0 and 1). It produces wb_err instead when RESP[1] is 1 (codes 2 and 3).
- R6: A request of the opposite direction to the outstanding transactions is not issued. It is issued one cycle after the edge at which the last outstanding response is counted.
- R7: No more than 2^LGFIFO transactions are outstanding. A further request is held until a response arrives, and it is then issued one cycle after the edge following that response.
- R8: Dropping wb_cyc while transactions are outstanding suppresses ack and err for all of them. New requests are stalled until the last of them has returned.
- R9: After an error response, the remaining outstanding responses produce neither ack nor err. Normal service resumes once they have drained.
- R10: A request that arrives while the bridge is blocked is captured, and wb_stall is high in the next cycle. The request is later issued intact. Dropping wb_cyc discards it, and it is never issued.
- R11: With the slave always ready, write requests on consecutive cycles are issued one per cycle, without raising wb_stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc | input | 1 | Wishbone cycle; low aborts |
| wb_stb | input | 1 | Wishbone request strobe |
| wb_we | input | 1 | Write when high |
| wb_adr | input | WB_AW | Word address |
| wb_dat_w | input | WB_DW | Write data |
| wb_sel | input | WB_DW/8 | Byte selects |
| wb_stall | output | 1 | Request not taken |
| wb_ack | output | 1 | Successful completion |
| wb_err | output | 1 | Failed completion |
| wb_dat_r | output | WB_DW | Read data |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awid | output | IDW | Write ID |
| m_awaddr | output | AXI_AW | Write byte address |
| m_awlen | output | 8 | Burst length (0) |
| m_awsize | output | 3 | Beat size |
| m_awburst | output | 2 | Burst type |
| m_awlock | output | 1 | Lock (0) |
| m_awcache | output | 4 | Cache attribute |
| m_awprot | output | 3 | Protection attribute |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | AXI_DW | Write data |
| m_wstrb | output | AXI_DW/8 | Write strobes |
| m_wlast | output | 1 | Last beat (1) |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_arid | output | IDW | Read ID |
| m_araddr | output | AXI_AW | Read byte address |
| m_arlen | output | 8 | Burst length (0) |
| m_arsize | output | 3 | Beat size |
| m_arburst | output | 2 | Burst type |
| m_arlock | output | 1 | Lock (0) |
| m_arcache | output | 4 | Cache attribute |
| m_arprot | output | 3 | Protection attribute |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | AXI_DW | Read data |
| m_rresp | input | 2 | Read response code |

## Verification
A request taken at an edge shows up on the AXI address and data channels one cycle later. A response sampled at an edge shows up as ack, err and read data one cycle later. A request held in the skid buffer is issued one cycle after the edge at which its blocking condition (a full counter, a pending direction reversal, or a flush) clears. The bench drives at the falling edge and samples at the next falling edge, so each check lands exactly in the cycle these latencies predict. The held-request cases also check that nothing appears in the cycles before that.

// File: rtl/wb2axi_bridge.sv
module wb2axi_bridge #(
  parameter int WB_DW  = 32,
  parameter int AXI_DW = 64,
  parameter int AXI_AW = 32,
  parameter int WB_AW  = AXI_AW - $clog2(WB_DW/8),
  parameter int LGFIFO = 3,
  parameter int IDW    = 2,
  parameter logic [IDW-1:0] WR_ID = '0,
  parameter logic [IDW-1:0] RD_ID = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [WB_AW-1:0]  wb_adr,
  input  logic [WB_DW-1:0]  wb_dat_w,
  input  logic [WB_DW/8-1:0] wb_sel,
  output logic              wb_stall,
  output logic              wb_ack,
  output logic              wb_err,
  output logic [WB_DW-1:0]  wb_dat_r,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [IDW-1:0]    m_awid,
  output logic [AXI_AW-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_awlock,
  output logic [3:0]        m_awcache,
  output logic [2:0]        m_awprot,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [AXI_DW-1:0] m_wdata,
  output logic [AXI_DW/8-1:0] m_wstrb,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [IDW-1:0]    m_arid,
  output logic [AXI_AW-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arlock,
  output logic [3:0]        m_arcache,
  output logic [2:0]        m_arprot,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [AXI_DW-1:0] m_rdata,
  input  logic [1:0]        m_rresp
);
  localparam int WB_SB    = WB_DW / 8;
  localparam int AXI_SB   = AXI_DW / 8;
  localparam int BYTE_LSB = $clog2(WB_SB);
  localparam int RATIO    = AXI_DW / WB_DW;
  localparam int SUBW     = $clog2(RATIO);
  localparam int SW1      = (SUBW > 0) ? SUBW : 1;
  localparam int DEPTH    = 1 << LGFIFO;
  localparam int CW       = LGFIFO + 1;

  // fixed attributes of a single-beat, single-ID master
  assign m_awid    = WR_ID;
  assign m_arid    = RD_ID;
  assign m_awlen   = 8'd0;
  assign m_arlen   = 8'd0;
  assign m_awsize  = 3'(BYTE_LSB);
  assign m_arsize  = 3'(BYTE_LSB);
  assign m_awburst = 2'b01;
  assign m_arburst = 2'b01;
  assign m_awlock  = 1'b0;
  assign m_arlock  = 1'b0;
  assign m_awcache = 4'h2;
  assign m_arcache = 4'h2;
  assign m_awprot  = 3'b010;
  assign m_arprot  = 3'b010;
  assign m_wlast   = 1'b1;
  assign m_bready  = 1'b1;
  assign m_rready  = 1'b1;

  logic              sk_v, sk_we;
  logic [WB_AW-1:0]  sk_adr;
  logic [WB_DW-1:0]  sk_dat;
  logic [WB_SB-1:0]  sk_sel;
  logic [CW-1:0]     cnt, cnt_nx;
  logic              cnt_empty, cnt_full, dir_we, flushing, busy;
  logic [SW1-1:0]    wr_sub, rd_sub;

  wire             req_v   = sk_v | (wb_cyc & wb_stb);
  wire             req_we  = sk_v ? sk_we  : wb_we;
  wire [WB_AW-1:0] req_adr = sk_v ? sk_adr : wb_adr;
  wire [WB_DW-1:0] req_dat = sk_v ? sk_dat : wb_dat_w;
  wire [WB_SB-1:0] req_sel = sk_v ? sk_sel : wb_sel;
  wire             accept  = wb_cyc & req_v & ~busy;
  wire             resp_err = (m_bvalid & m_bresp[1]) | (m_rvalid & m_rresp[1]);
  wire             resp_ok  = (m_bvalid & ~m_bresp[1]) | (m_rvalid & ~m_rresp[1]);
  wire             unused_resp = m_bresp[0] ^ m_rresp[0];

  assign busy = flushing | cnt_full
              | (m_awvalid & ~m_awready) | (m_wvalid & ~m_wready) | (m_arvalid & ~m_arready)
              | (~cnt_empty & (req_we != dir_we));
  assign wb_stall = sk_v;

  // input skid buffer
  always_ff @(posedge clk) begin
    if (!rst_n || !wb_cyc) sk_v <= 1'b0;
    else if (!sk_v)        sk_v <= wb_stb & busy;
    else if (!busy)        sk_v <= 1'b0;
    if (!sk_v) begin
      sk_we <= wb_we; sk_adr <= wb_adr; sk_dat <= wb_dat_w; sk_sel <= wb_sel;
    end
  end

  // outstanding transaction count and direction
  always_comb cnt_nx = cnt + CW'(accept) - CW'(m_bvalid | m_rvalid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; cnt_empty <= 1'b1; cnt_full <= 1'b0; dir_we <= 1'b0; flushing <= 1'b0;
    end else begin
      cnt       <= cnt_nx;
      cnt_empty <= (cnt_nx == '0);
      cnt_full  <= (cnt_nx == CW'(DEPTH));
      if (accept) dir_we <= req_we;
      flushing  <= (flushing | resp_err | (~wb_cyc & ~cnt_empty)) & (cnt_nx != '0);
    end
  end

  // request channels
  generate
    if (SUBW > 0) begin : g_wsub
      assign wr_sub = req_adr[SUBW-1:0];
    end else begin : g_wnosub
      assign wr_sub = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_awvalid <= 1'b0; m_wvalid <= 1'b0; m_arvalid <= 1'b0;
    end else begin
      if (accept & req_we)   m_awvalid <= 1'b1;
      else if (m_awready)    m_awvalid <= 1'b0;
      if (accept & req_we)   m_wvalid  <= 1'b1;
      else if (m_wready)     m_wvalid  <= 1'b0;
      if (accept & ~req_we)  m_arvalid <= 1'b1;
      else if (m_arready)    m_arvalid <= 1'b0;
    end
    if (!m_awvalid || m_awready) m_awaddr <= AXI_AW'(req_adr) << BYTE_LSB;
    if (!m_arvalid || m_arready) m_araddr <= AXI_AW'(req_adr) << BYTE_LSB;
    if (!m_wvalid || m_wready) begin
      m_wdata <= {RATIO{req_dat}};
      m_wstrb <= AXI_SB'(req_sel) << (int'(wr_sub) * WB_SB);
    end
  end

  // lane queue for read returns; pointers follow in-flight traffic, not flushes
  generate
    if (SUBW > 0) begin : g_lane
      logic [SUBW-1:0]   lane_q [DEPTH];
      logic [LGFIFO-1:0] wp, rp;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wp <= '0; rp <= '0;
        end else begin
          if (accept & ~req_we) begin
            lane_q[wp] <= wr_sub;
            wp <= wp + 1'b1;
          end
          if (m_rvalid) rp <= rp + 1'b1;
        end
      end
      assign rd_sub = lane_q[rp];
    end else begin : g_nolane
      assign rd_sub = '0;
    end
  endgenerate

  // response path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ack <= 1'b0; wb_err <= 1'b0;
    end else begin
      wb_ack <= wb_cyc & ~flushing & resp_ok;
      wb_err <= wb_cyc & ~flushing & resp_err;
    end
    if (m_rvalid) wb_dat_r <= m_rdata[int'(rd_sub) * WB_DW +: WB_DW];
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r6_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_arvalid && (m_awvalid || m_wvalid)));
  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> !wb_ack && !wb_err);
  a_r2_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  a_r8_drain_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flushing) |-> cnt == '0);
endmodule

// File: tb/wb2axi_bridge_tb.sv
module wb2axi_bridge_tb_top;
  localparam int AAW = 16;
  localparam int WAW = AAW - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [WAW-1:0] wb_adr = '0;
  logic [31:0] wb_dat_w = '0;
  logic [3:0]  wb_sel = '0;
  logic wb_stall, wb_ack, wb_err;
  logic [31:0] wb_dat_r;
  logic m_awvalid, m_awready = 1, m_wvalid, m_wready = 1, m_wlast;
  logic [1:0] m_awid, m_arid, m_awburst, m_arburst;
  logic [AAW-1:0] m_awaddr, m_araddr;
  logic [7:0] m_awlen, m_arlen;
  logic [2:0] m_awsize, m_arsize, m_awprot, m_arprot;
  logic m_awlock, m_arlock;
  logic [3:0] m_awcache, m_arcache;
  logic [63:0] m_wdata;
  logic [7:0]  m_wstrb;
  logic m_bvalid = 0, m_bready;
  logic [1:0] m_bresp = 0;
  logic m_arvalid, m_arready = 1;
  logic m_rvalid = 0, m_rready;
  logic [63:0] m_rdata = '0;
  logic [1:0] m_rresp = 0;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  wb2axi_bridge #(.WB_DW(32), .AXI_DW(64), .AXI_AW(AAW), .WB_AW(WAW), .LGFIFO(2),
                  .IDW(2), .WR_ID(2'd1), .RD_ID(2'd2)) dut_i (
    .clk, .rst_n, .wb_cyc, .wb_stb, .wb_we, .wb_adr, .wb_dat_w, .wb_sel,
    .wb_stall, .wb_ack, .wb_err, .wb_dat_r,
    .m_awvalid, .m_awready, .m_awid, .m_awaddr, .m_awlen, .m_awsize, .m_awburst,
    .m_awlock, .m_awcache, .m_awprot,
    .m_wvalid, .m_wready, .m_wdata, .m_wstrb, .m_wlast,
    .m_bvalid, .m_bready, .m_bresp,
    .m_arvalid, .m_arready, .m_arid, .m_araddr, .m_arlen, .m_arsize, .m_arburst,
    .m_arlock, .m_arcache, .m_arprot,
    .m_rvalid, .m_rready, .m_rdata, .m_rresp);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic nxt(); @(negedge clk); endtask

  task automatic req(input bit we, input int adr, input logic [31:0] dat, input logic [3:0] sel);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = WAW'(adr); wb_dat_w = dat; wb_sel = sel;
  endtask

  function automatic logic [63:0] rword(input int a);
    return {32'h1000_0000 + 32'(a), 32'h2000_0000 + 32'(a)};
  endfunction

  function automatic logic [31:0] rexp(input int a);
    return (a % 2 == 1) ? 32'h1000_0000 + 32'(a) : 32'h2000_0000 + 32'(a);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    nxt(); nxt();
    chk("R1", "reset stall", wb_stall, 0);
    chk("R1", "reset ack", wb_ack, 0);
    chk("R1", "reset awvalid", m_awvalid, 0);
    chk("R1", "reset wvalid", m_wvalid, 0);
    chk("R1", "reset arvalid", m_arvalid, 0);
    nxt(); rst_n = 1; nxt();
    // R1 fixed attributes
    chk("R1", "awlen", m_awlen, 0);      chk("R1", "arlen", m_arlen, 0);
    chk("R1", "wlast", m_wlast, 1);
    chk("R1", "awid", m_awid, 1);        chk("R1", "arid", m_arid, 2);
    chk("R1", "awsize", m_awsize, 2);    chk("R1", "arsize", m_arsize, 2);
    chk("R1", "awburst", m_awburst, 1);  chk("R1", "arburst", m_arburst, 1);
    chk("R1", "awlock", m_awlock, 0);    chk("R1", "arlock", m_arlock, 0);
    chk("R1", "awcache", m_awcache, 2);  chk("R1", "arcache", m_arcache, 2);
    chk("R1", "awprot", m_awprot, 2);    chk("R1", "arprot", m_arprot, 2);
    chk("R1", "bready", m_bready, 1);    chk("R1", "rready", m_rready, 1);

    // R2 R3 write sweep over address parity and every strobe pattern
    for (int a = 0; a < 8; a++) begin
      for (int s = 0; s < 16; s++) begin
        logic [31:0] d;
        d = 32'hA500_0000 | 32'(a << 8) | 32'(s);
        req(1, a, d, 4'(s));
        nxt();
        chk("R2", "awvalid", m_awvalid, 1);
        chk("R2", "wvalid", m_wvalid, 1);
        chk("R2", "awaddr", m_awaddr, 64'(a * 4));
        chk("R3", "wdata", m_wdata, {d, d});
        chk("R3", "wstrb", m_wstrb, 64'(8'(s) << (4 * (a % 2))));
        wb_stb = 0;
        nxt();
        chk("R2", "awvalid cleared", m_awvalid, 0);
        m_bvalid = 1; m_bresp = 0;
        nxt();
        m_bvalid = 0;
        chk("R5", "write ack", wb_ack, 1);
        chk("R5", "write err", wb_err, 0);
      end
    end

    // R4 read sweep
    for (int a = 0; a < 8; a++) begin
      req(0, a, 0, 4'hF);
      nxt();
      chk("R4", "arvalid", m_arvalid, 1);
      chk("R4", "araddr", m_araddr, 64'(a * 4));
      chk("R4", "no awvalid", m_awvalid, 0);
      wb_stb = 0;
      nxt();
      m_rvalid = 1; m_rresp = 0; m_rdata = rword(a);
      nxt();
      m_rvalid = 0;
      chk("R4", "read ack", wb_ack, 1);
      chk("R4", "read data", wb_dat_r, rexp(a));
    end

    // R5 response code sweep, both directions
    for (int r = 0; r < 4; r++) begin
      req(1, 3, 32'h55, 4'hF); nxt(); wb_stb = 0; nxt();
      m_bvalid = 1; m_bresp = 2'(r); nxt(); m_bvalid = 0;
      chk("R5", "bresp ack", wb_ack, 64'(r < 2));
      chk("R5", "bresp err", wb_err, 64'(r >= 2));
      req(0, 5, 0, 4'hF); nxt(); wb_stb = 0; nxt();
      m_rvalid = 1; m_rresp = 2'(r); m_rdata = rword(5); nxt(); m_rvalid = 0;
      chk("R5", "rresp ack", wb_ack, 64'(r < 2));
      chk("R5", "rresp err", wb_err, 64'(r >= 2));
    end
    m_bresp = 0; m_rresp = 0;

    // R11 back-to-back writes
    for (int i = 0; i < 4; i++) begin
      req(1, 16 + i, 32'(i), 4'hF);
      nxt();
      chk("R11", "awvalid", m_awvalid, 1);
      chk("R11", "awaddr", m_awaddr, 64'((16 + i) * 4));
      chk("R11", "no stall", wb_stall, 0);
    end
    wb_stb = 0; nxt();
    m_bvalid = 1;
    for (int i = 0; i < 4; i++) begin
      nxt();
      chk("R11", "ack", wb_ack, 1);
    end
    m_bvalid = 0; nxt();

    // R7 outstanding limit with lane ordering
    for (int i = 0; i < 5; i++) begin
      req(0, 8 + i, 0, 4'hF);
      nxt();
      if (i < 4) begin
        chk("R7", "arvalid", m_arvalid, 1);
        chk("R7", "araddr", m_araddr, 64'((8 + i) * 4));
      end else begin
        chk("R7", "stall at limit", wb_stall, 1);
        chk("R7", "no issue at limit", m_arvalid, 0);
      end
    end
    wb_stb = 0;
    for (int i = 0; i < 3; i++) begin
      nxt();
      chk("R7", "held", m_arvalid, 0);
    end
    m_rvalid = 1; m_rdata = rword(8);
    nxt();
    m_rvalid = 0;
    chk("R7", "first ack", wb_ack, 1);
    chk("R4", "first data", wb_dat_r, rexp(8));
    chk("R7", "not yet", m_arvalid, 0);
    nxt();
    chk("R7", "issued", m_arvalid, 1);
    chk("R7", "issued addr", m_araddr, 64'(12 * 4));
    chk("R10", "stall released", wb_stall, 0);
    nxt();
    for (int i = 9; i < 13; i++) begin
      m_rvalid = 1; m_rdata = rword(i);
      nxt();
      chk("R7", "drain ack", wb_ack, 1);
      chk("R4", "ordered data", wb_dat_r, rexp(i));
    end
    m_rvalid = 0; nxt();

    // R6 direction reversal waits for drain
    req(1, 5, 32'h77, 4'hF); nxt();
    chk("R6", "write issued", m_awvalid, 1);
    req(0, 6, 0, 4'hF); nxt();
    chk("R6", "reversal stalled", wb_stall, 1);
    chk("R6", "no read", m_arvalid, 0);
    wb_stb = 0;
    for (int i = 0; i < 2; i++) begin
      nxt();
      chk("R6", "read held", m_arvalid, 0);
    end
    m_bvalid = 1; nxt(); m_bvalid = 0;
    chk("R6", "write ack", wb_ack, 1);
    chk("R6", "read still held", m_arvalid, 0);
    nxt();
    chk("R6", "read issued", m_arvalid, 1);
    chk("R6", "read addr", m_araddr, 64'(24));
    nxt();
    m_rvalid = 1; m_rdata = rword(6); nxt(); m_rvalid = 0;
    chk("R6", "read ack", wb_ack, 1);
    chk("R6", "read data", wb_dat_r, rexp(6));

    // R8 abort
    req(0, 20, 0, 4'hF); nxt();
    req(0, 21, 0, 4'hF); nxt();
    wb_cyc = 0; wb_stb = 0; nxt();
    req(0, 22, 0, 4'hF); nxt();
    chk("R8", "stall while flushing", wb_stall, 1);
    chk("R8", "no issue while flushing", m_arvalid, 0);
    wb_stb = 0;
    m_rvalid = 1; m_rdata = rword(20); nxt();
    chk("R8", "ack suppressed 1", wb_ack, 0);
    m_rdata = rword(21); nxt();
    m_rvalid = 0;
    chk("R8", "ack suppressed 2", wb_ack, 0);
    chk("R8", "err suppressed", wb_err, 0);
    nxt();
    chk("R8", "resume issue", m_arvalid, 1);
    chk("R8", "resume addr", m_araddr, 64'(88));
    nxt();
    m_rvalid = 1; m_rdata = rword(22); nxt(); m_rvalid = 0;
    chk("R8", "resume ack", wb_ack, 1);
    chk("R8", "resume data", wb_dat_r, rexp(22));

    // R9 error flush
    for (int i = 0; i < 3; i++) begin
      req(1, 30 + i, 32'(i), 4'hF); nxt();
    end
    wb_stb = 0; nxt();
    m_bvalid = 1; m_bresp = 2; nxt();
    chk("R9", "error reported", wb_err, 1);
    chk("R9", "no ack on error", wb_ack, 0);
    m_bresp = 0; nxt();
    chk("R9", "flushed ack 1", wb_ack, 0);
    nxt();
    m_bvalid = 0;
    chk("R9", "flushed ack 2", wb_ack, 0);
    chk("R9", "flushed err", wb_err, 0);
    req(1, 33, 32'h99, 4'hF); nxt();
    chk("R9", "service resumes", m_awvalid, 1);
    wb_stb = 0; nxt();
    m_bvalid = 1; nxt(); m_bvalid = 0;
    chk("R9", "resumed ack", wb_ack, 1);

    // R2 independent hold of address and data channels, R10 capture
    m_awready = 0;
    req(1, 50, 32'h5050, 4'hF); nxt();
    chk("R2", "aw up", m_awvalid, 1);
    chk("R2", "w up", m_wvalid, 1);
    req(1, 51, 32'h5151, 4'h3); nxt();
    chk("R2", "w done alone", m_wvalid, 0);
    chk("R2", "aw held", m_awvalid, 1);
    chk("R2", "aw addr held", m_awaddr, 64'(200));
    chk("R10", "captured", wb_stall, 1);
    wb_stb = 0; m_awready = 1; nxt();
    chk("R10", "captured issued addr", m_awaddr, 64'(204));
    chk("R10", "captured data", m_wdata, {32'h5151, 32'h5151});
    chk("R10", "captured strobe", m_wstrb, 64'h30);
    chk("R10", "stall cleared", wb_stall, 0);
    nxt();
    m_bvalid = 1; nxt();
    chk("R2", "ack 1", wb_ack, 1);
    nxt(); m_bvalid = 0;
    chk("R2", "ack 2", wb_ack, 1);

    // R10 dropping cyc discards a captured request
    req(1, 40, 32'h40, 4'hF); nxt();
    req(0, 41, 0, 4'hF); nxt();
    chk("R10", "held behind write", wb_stall, 1);
    wb_cyc = 0; wb_stb = 0; nxt();
    chk("R10", "buffer cleared", wb_stall, 0);
    m_bvalid = 1; nxt(); m_bvalid = 0;
    chk("R10", "abort ack suppressed", wb_ack, 0);
    for (int i = 0; i < 4; i++) begin
      nxt();
      chk("R10", "discarded never issued", m_arvalid, 0);
    end
    req(0, 42, 0, 4'hF); nxt();
    chk("R10", "fresh read", m_araddr, 64'(168));
    wb_stb = 0; nxt();
    m_rvalid = 1; m_rdata = rword(42); nxt(); m_rvalid = 0;
    chk("R10", "fresh ack", wb_ack, 1);
    chk("R10", "fresh data", wb_dat_r, rexp(42));

    nxt();
    finish_run();
  end
endmodule